// File: doc/BRIEF.md
# Configurable Serial Character Transmitter

This block turns one parallel character at a time into an asynchronous serial frame on a single output line. A frame is a start bit at space (0), then five to eight data bits sent least significant bit first, then an optional parity bit, then a stop period at mark (1). The line rests at mark between frames. Bit timing comes from an external strobe that pulses once per sixteenth of a bit. Every bit, including the start bit and each data bit, lasts sixteen of these strobes.

Characters enter through a valid/ready port. `in_ready` is high only while the transmitter is idle. A character is taken on a clock edge where `in_valid` and `in_ready` are both high. While a frame is in flight, `in_ready` stays low and `in_valid` is ignored, so a producer that holds its data waits without loss. The frame shape inputs (word length, stop length, parity controls) are captured at the accepting edge and hold for the whole frame. The break input is not captured. It acts directly on the output register, and while it is high it forces the line to space.

Top module: `serial_tx_framer`

## Requirements
- R1: After reset, and whenever the block is idle with break low, `tx_o` is 1, `busy` is 0 and `in_ready` is 1.
- R2: A character is accepted on an edge where `in_valid` and `in_ready` are both high, and `busy` is 1 after that edge. While `busy` is 1, `in_ready` is 0 and `in_valid` has no effect: no second frame follows unless valid is high again once the block is idle.
- R3: A frame starts with a start bit of 0 on `tx_o` one clock after acceptance. Each start, data and parity bit lasts exactly 16 baud ticks. Data bits are sent least significant bit first.
- R4: `cfg_wlen` selects the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7, 11 gives 8. Data bits above the selected length are not sent.
- R5: The stop period is 1 during all of its ticks. It lasts 16 ticks when `cfg_stop_long` is 0. When `cfg_stop_long` is 1, it lasts 24 ticks for 5-bit words and 32 ticks for 6-, 7- and 8-bit words.
- R6: When `cfg_par_en` is 0, no parity bit is sent. When it is 1, one parity bit of 16 ticks sits between the last data bit and the stop period.
- R7: With parity enabled and `cfg_par_stick` at 0, `cfg_par_even` = 0 makes the count of 1s across the sent data bits plus the parity bit odd. `cfg_par_even` = 1 makes that count even.
- R8: With parity enabled and `cfg_par_stick` at 1, the parity bit is 1 when `cfg_par_even` is 0, and 0 when `cfg_par_even` is 1, whatever the data.
- R9: From the clock after `cfg_break` goes high until the clock after it goes low, `tx_o` is 0, whether the block is idle or sending. The frame sequence keeps running underneath, so the frame's length in ticks does not change.
- R10: Changes to the frame shape inputs during a frame do not change that frame.
- R11: `busy` falls right after the last stop tick is counted. A new character can then be accepted, and back-to-back frames are sent correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-clock strobe at 16 times the bit rate |
| in_data | input | 8 | Character to send; unused upper bits are ignored |
| in_valid | input | 1 | Character on `in_data` is offered |
| in_ready | output | 1 | Transmitter is idle and takes the offered character |
| cfg_wlen | input | 2 | Data bit count select (5 to 8) |
| cfg_stop_long | input | 1 | Long stop period select |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_even | input | 1 | Even parity / space when stuck |
| cfg_par_stick | input | 1 | Constant parity bit select |
| cfg_break | input | 1 | Hold the line at space |
| tx_o | output | 1 | Serial line |
| busy | output | 1 | Frame in progress |

## Verification
The assertions assume that `baud_tick` is a single-clock pulse and never high on two clocks in a row. They also assume that the shape inputs and `in_data` are stable on the accepting edge. The bench produces every tick itself, as a one-clock pulse every third clock. It offers characters only on a clock between ticks, so an acceptance never falls on the same edge as a tick. Break and mid-frame input changes are applied at known tick counts, so each expected line level can be worked out per tick from the requirements.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } tx_state_e;

  // Frame shape captured at acceptance
  typedef struct packed {
    logic [1:0] wlen;
    logic       stop_long;
    logic       par_en;
  } frame_shape_t;

endpackage

// File: rtl/tx_bit_timer.sv
module tx_bit_timer #(
  parameter int TICKS_PER_BIT = 16,
  localparam int CW = $clog2(2 * TICKS_PER_BIT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic [CW-1:0] last,
  output logic          bit_done
);

  logic [CW-1:0] cnt;

  assign bit_done = run && tick && (cnt == last);

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (!run || bit_done) cnt <= '0;
    else if (tick)             cnt <= cnt + 1'b1;
  end

  // Tick counter never passes the end of the current bit
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= last));

endmodule

// File: rtl/tx_parity_unit.sv
module tx_parity_unit #(
  parameter int DATA_W = 8,
  localparam int MIN_WORD = DATA_W - 3
) (
  input  logic [DATA_W-1:0] data,
  input  logic [1:0]        wlen,
  input  logic              par_even,
  input  logic              par_stick,
  output logic              par_bit
);

  logic [DATA_W-1:0] masked;
  logic              ones_odd;

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      masked[i] = data[i] & (i < (MIN_WORD + int'(wlen)));
    end
    ones_odd = ^masked;
    if (par_stick)     par_bit = !par_even;
    else if (par_even) par_bit = ones_odd;
    else               par_bit = !ones_odd;
  end

endmodule

// File: rtl/tx_sequencer.sv
module tx_sequencer
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TICKS_PER_BIT = 16,
  localparam int IW = $clog2(DATA_W),
  localparam int CW = $clog2(2 * TICKS_PER_BIT),
  localparam int MIN_WORD = DATA_W - 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  frame_shape_t      shape_in,
  input  logic              par_bit_in,
  input  logic              bit_done,
  output logic              run,
  output logic [CW-1:0]     bit_last,
  output logic              line,
  output logic              busy
);

  tx_state_e         state;
  frame_shape_t      shape_q;
  logic [DATA_W-1:0] shreg;
  logic [IW-1:0]     bit_idx;
  logic              par_q;
  logic [IW-1:0]     last_idx;
  logic              accept;

  assign in_ready = (state == ST_IDLE);
  assign busy     = !in_ready;
  assign run      = busy;
  assign accept   = in_valid && in_ready;
  assign last_idx = IW'(MIN_WORD - 1) + IW'(shape_q.wlen);

  always_comb begin
    if (state == ST_STOP && shape_q.stop_long) begin
      if (shape_q.wlen == 2'b00) bit_last = CW'((3 * TICKS_PER_BIT) / 2 - 1);
      else                       bit_last = CW'(2 * TICKS_PER_BIT - 1);
    end else begin
      bit_last = CW'(TICKS_PER_BIT - 1);
    end
  end

  always_comb begin
    unique case (state)
      ST_START:  line = 1'b0;
      ST_DATA:   line = shreg[0];
      ST_PARITY: line = par_q;
      default:   line = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      shape_q <= '0;
      shreg   <= '0;
      bit_idx <= '0;
      par_q   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          state   <= ST_START;
          shape_q <= shape_in;
          shreg   <= in_data;
          par_q   <= par_bit_in;
          bit_idx <= '0;
        end
        ST_START: if (bit_done) state <= ST_DATA;
        ST_DATA: if (bit_done) begin
          shreg   <= shreg >> 1;
          bit_idx <= bit_idx + 1'b1;
          if (bit_idx == last_idx) state <= shape_q.par_en ? ST_PARITY : ST_STOP;
        end
        ST_PARITY: if (bit_done) state <= ST_STOP;
        ST_STOP:   if (bit_done) state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> busy);

  p_shape_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(shape_q));

  p_data_index_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA) |-> (bit_idx <= last_idx));

endmodule

// File: rtl/serial_tx_framer.sv
module serial_tx_framer
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TICKS_PER_BIT = 16,
  localparam int CW = $clog2(2 * TICKS_PER_BIT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        cfg_wlen,
  input  logic              cfg_stop_long,
  input  logic              cfg_par_en,
  input  logic              cfg_par_even,
  input  logic              cfg_par_stick,
  input  logic              cfg_break,
  output logic              tx_o,
  output logic              busy
);

  frame_shape_t  shape_in;
  logic          par_bit;
  logic          bit_done;
  logic          run;
  logic [CW-1:0] bit_last;
  logic          line;
  logic          tx_q;

  assign shape_in = '{wlen: cfg_wlen, stop_long: cfg_stop_long, par_en: cfg_par_en};

  tx_parity_unit #(.DATA_W(DATA_W)) u_par (
    .data      (in_data),
    .wlen      (cfg_wlen),
    .par_even  (cfg_par_even),
    .par_stick (cfg_par_stick),
    .par_bit   (par_bit)
  );

  tx_bit_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .tick     (baud_tick),
    .last     (bit_last),
    .bit_done (bit_done)
  );

  tx_sequencer #(.DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_data    (in_data),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .shape_in   (shape_in),
    .par_bit_in (par_bit),
    .bit_done   (bit_done),
    .run        (run),
    .bit_last   (bit_last),
    .line       (line),
    .busy       (busy)
  );

  // Break overrides the output register only
  always_ff @(posedge clk) begin
    if (!rst_n)         tx_q <= 1'b1;
    else if (cfg_break) tx_q <= 1'b0;
    else                tx_q <= line;
  end

  assign tx_o = tx_q;

  p_break_space_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_break |=> !tx_o);

  p_idle_mark_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cfg_break) |=> tx_o);

  p_start_space_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !cfg_break) |=> !tx_o);

endmodule

// File: tb/serial_tx_framer_test.sv
module serial_tx_framer_test;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       baud_tick = 0;
  logic [7:0] in_data = 0;
  logic       in_valid = 0;
  logic       in_ready;
  logic [1:0] cfg_wlen = 2'b11;
  logic       cfg_stop_long = 0;
  logic       cfg_par_en = 0;
  logic       cfg_par_even = 0;
  logic       cfg_par_stick = 0;
  logic       cfg_break = 0;
  logic       tx_o;
  logic       busy;

  int checks = 0;
  int fails = 0;
  bit samp [0:699];

  always #5 clk = ~clk;

  serial_tx_framer uut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .cfg_wlen(cfg_wlen),
    .cfg_stop_long(cfg_stop_long), .cfg_par_en(cfg_par_en),
    .cfg_par_even(cfg_par_even), .cfg_par_stick(cfg_par_stick),
    .cfg_break(cfg_break), .tx_o(tx_o), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // mode 0 plain, 1 break during frame, 2 shape change and valid during frame
  task automatic run_frame(input logic [7:0] d, input logic [1:0] wl, input bit sl,
                           input bit pe, input bit pv, input bit ps, input int mode);
    int n = 0;
    int w = 5 + int'(wl);
    int ones = 0;
    bit pbit;
    int stop_t;
    int total;
    @(negedge clk);
    in_data = d; cfg_wlen = wl; cfg_stop_long = sl;
    cfg_par_en = pe; cfg_par_even = pv; cfg_par_stick = ps;
    in_valid = 1;
    chk(in_ready == 1, "R2 ready before accept", int'(in_ready), 1);
    @(negedge clk);
    in_valid = 0;
    chk(busy == 1, "R2 busy after accept", int'(busy), 1);
    chk(in_ready == 0, "R2 ready low while busy", int'(in_ready), 0);
    @(negedge clk); @(negedge clk);
    while (busy && n < 700) begin
      if (mode == 1 && n == 20) cfg_break = 1;
      if (mode == 1 && n == 52) cfg_break = 0;
      if (mode == 2 && n == 20) begin
        chk(in_ready == 0, "R2 ready low mid frame", int'(in_ready), 0);
        cfg_wlen = ~wl; cfg_stop_long = ~sl; cfg_par_en = ~pe;
        in_data = ~d; in_valid = 1;
      end
      if (mode == 2 && n == 40) in_valid = 0;
      samp[n] = tx_o;
      baud_tick = 1;
      @(negedge clk);
      baud_tick = 0;
      @(negedge clk); @(negedge clk);
      n++;
    end
    for (int i = 0; i < w; i++) ones += int'(d[i]);
    if (ps) pbit = !pv;
    else if (pv) pbit = (ones % 2) == 1;
    else pbit = (ones % 2) == 0;
    stop_t = !sl ? 16 : (w == 5 ? 24 : 32);
    total = 16 * (1 + w + int'(pe)) + stop_t;
    chk(n == total, "R5/R10 frame length in ticks", n, total);
    for (int b = 0; b < 1 + w + int'(pe); b++) begin
      int idx = 16 * b + 8;
      bit exp;
      if (b == 0) exp = 0;
      else if (b <= w) exp = d[b-1];
      else exp = pbit;
      if (mode == 1 && idx >= 21 && idx <= 52) exp = 0;
      if (b == 0) chk(samp[idx] == exp, "R3 start bit", int'(samp[idx]), int'(exp));
      else if (b <= w) chk(samp[idx] == exp, "R3/R4 data bit", int'(samp[idx]), int'(exp));
      else chk(samp[idx] == exp, "R6/R7/R8 parity bit", int'(samp[idx]), int'(exp));
    end
    for (int i = 16 * (1 + w + int'(pe)); i < n; i++)
      if (samp[i] != 1) chk(0, "R5 stop level", int'(samp[i]), 1);
    if (mode == 1) begin
      int low = 0;
      for (int i = 21; i <= 52; i++) low += int'(samp[i] == 0);
      chk(low == 32, "R9 break holds space in frame", low, 32);
      chk(samp[53] == 1 || 53 < 16, "R9 line released after break", int'(samp[53]), 1);
    end
    chk(in_ready == 1, "R11 ready after frame", int'(in_ready), 1);
    if (mode == 2) begin
      repeat (5) @(negedge clk);
      chk(busy == 0, "R2 valid ignored while busy", int'(busy), 0);
    end
  endtask

  task automatic t_reset;
    chk(tx_o == 1, "R1 reset line", int'(tx_o), 1);
    chk(busy == 0, "R1 reset busy", int'(busy), 0);
    chk(in_ready == 1, "R1 reset ready", int'(in_ready), 1);
  endtask

  task automatic t_plain_8n1;      run_frame(8'hA5, 2'b11, 0, 0, 0, 0, 0); endtask
  task automatic t_word5_long;     run_frame(8'hF3, 2'b00, 1, 0, 0, 0, 0); endtask
  task automatic t_word6_long;     run_frame(8'h2D, 2'b01, 1, 0, 0, 0, 0); endtask
  task automatic t_odd_parity;     run_frame(8'h35, 2'b10, 0, 1, 0, 0, 0); endtask
  task automatic t_even_parity;    run_frame(8'hB7, 2'b11, 0, 1, 1, 0, 0); endtask
  task automatic t_odd_parity5;    run_frame(8'hE0, 2'b00, 1, 1, 0, 0, 0); endtask
  task automatic t_stick_mark;     run_frame(8'h0F, 2'b11, 0, 1, 0, 1, 0); endtask
  task automatic t_stick_space;    run_frame(8'h01, 2'b11, 1, 1, 1, 1, 0); endtask
  task automatic t_break_frame;    run_frame(8'hFF, 2'b11, 0, 0, 0, 0, 1); endtask
  task automatic t_shape_hold;     run_frame(8'h5A, 2'b00, 0, 0, 0, 0, 2); endtask

  task automatic t_back_to_back;
    run_frame(8'h81, 2'b11, 0, 1, 1, 0, 0);
    run_frame(8'h7E, 2'b10, 1, 1, 0, 0, 0);
  endtask

  task automatic t_break_idle;
    @(negedge clk); cfg_break = 1;
    @(negedge clk);
    chk(tx_o == 0, "R9 break while idle", int'(tx_o), 0);
    repeat (4) @(negedge clk);
    chk(tx_o == 0, "R9 break held", int'(tx_o), 0);
    chk(busy == 0, "R9 break starts no frame", int'(busy), 0);
    cfg_break = 0;
    @(negedge clk);
    chk(tx_o == 1, "R1 line mark after break", int'(tx_o), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_plain_8n1;
    t_word5_long;
    t_word6_long;
    t_odd_parity;
    t_even_parity;
    t_odd_parity5;
    t_stick_mark;
    t_stick_space;
    t_break_idle;
    t_break_frame;
    t_shape_hold;
    t_back_to_back;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule